// File: doc/BRIEF.md
# Address-Tagged Two-Bit Branch Predictor

This block holds a small, fully associative table of two-bit saturating counters, each paired with the full branch address it belongs to and a valid flag. A fetch stage presents a branch address on the lookup port and gets a taken or not-taken guess back in the same cycle, with no register between address and prediction. When the branch later resolves, the execute stage presents the same address and the real outcome on the update port, and the matching counter moves one step toward that outcome.

Entries are created on demand. An address the table has never seen is predicted taken. Its entry starts in the weakly-taken state, either when it is first looked up or when it is first updated. Free entries are filled from the lowest index upward. Once all entries are in use, a rotating pointer picks which entry a newcomer overwrites.

Top module: `bpred_tagged`

## Requirements
- R1: Reset marks every entry empty, so after reset any lookup predicts taken, whatever the table held before.
- R2: A lookup of an address with no entry predicts taken (1) and, at the next clock edge, creates an entry for it with counter value 2.
- R3: A lookup of an address with an entry predicts taken when its counter is 2 or 3 and not taken (0) when it is 0 or 1.
- R4: An update with outcome taken (up_taken=1) raises the entry's counter by one, holding at 3.
- R5: An update with outcome not taken (up_taken=0) lowers the entry's counter by one, holding at 0.
- R6: From counter 3 one not-taken update leaves the prediction taken and a second flips it; from counter 0 two taken updates are needed to flip it.
- R7: An update of an address with no entry creates one at 2 and applies the outcome at once, so the counter becomes 3 for taken and 1 for not taken.
- R8: When a lookup and an update name the same address in the same cycle, the prediction comes from the counter as it was before that update.
- R9: A new entry goes into the lowest-numbered empty slot. When no slot is empty, it replaces the slot under a rotating pointer that starts at slot 0 after reset and moves forward by one, wrapping around, after each replacement.
- R10: At most one entry is created per cycle. If the lookup and the update both miss on different addresses, only the update's entry is created. If both miss on the same address, a single entry is created and the update's outcome is applied to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | ADDR_W | Branch address being looked up |
| lk_taken | output | 1 | Prediction for lk_addr, 1 = taken |
| up_valid | input | 1 | A resolved outcome is presented this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench walks a single branch through every counter value and shows that a strong state needs two opposite outcomes before the guess flips. A counter that flipped after one, or wrapped past 0 or 3, would give a wrong guess on the next lookup. It presents a lookup and an update on the same address in one cycle. A design that bypassed the new value there would return the post-update guess. It fills the table, then brings in new addresses so that known entries are evicted. A wrong victim order would leave a trained address alive, or destroy one that should survive, and the next lookup of that address would give a changed prediction. A final mixed run drives both ports at once with more addresses than entries, including both-miss cycles, where a second allocation in one cycle would shift later victims.

// File: rtl/bpred_tagged.sv
module bpred_tagged #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [ADDR_W-1:0]  tags [ENTRIES];
  logic [1:0]         ctrs [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic             lk_hit, up_hit, free_any;
  logic [IDX_W-1:0] lk_idx, up_idx, free_idx, alloc_idx;

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0;
    up_hit = 1'b0; up_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid[i] && tags[i] == lk_addr) begin
        lk_hit = 1'b1; lk_idx = IDX_W'(i);
      end
      if (valid[i] && tags[i] == up_addr) begin
        up_hit = 1'b1; up_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
  end

  assign alloc_idx = free_any ? free_idx : rr_ptr;
  assign lk_taken  = lk_hit ? ctrs[lk_idx][1] : 1'b1;

  function automatic logic [1:0] step_ctr(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    else   return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  logic up_alloc, lk_alloc, do_alloc;
  assign up_alloc = up_valid && !up_hit;
  assign lk_alloc = lk_valid && !lk_hit && !up_alloc;
  assign do_alloc = up_alloc || lk_alloc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else begin
      if (up_valid && up_hit)
        ctrs[up_idx] <= step_ctr(ctrs[up_idx], up_taken);
      if (do_alloc) begin
        valid[alloc_idx] <= 1'b1;
        tags[alloc_idx]  <= up_alloc ? up_addr : lk_addr;
        ctrs[alloc_idx]  <= up_alloc ? (up_taken ? 2'd3 : 2'd1) : 2'd2;
        if (!free_any)
          rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
    end
  end
endmodule

module bpred_tagged_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_taken,
  input logic [ENTRIES-1:0] valid,
  input logic [IDX_W-1:0]  rr_ptr
);
  p_empty_pred_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && valid == '0) |-> lk_taken);

  p_one_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(valid & ~$past(valid)) <= 1);

  p_never_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(valid) & ~valid) == '0));

  p_rr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid) |=> $stable(rr_ptr));

  p_taken_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && up_valid && lk_addr == up_addr && up_taken && lk_taken)
    |=> (!(lk_valid && lk_addr == $past(lk_addr)) || lk_taken));

  p_nt_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && up_valid && lk_addr == up_addr && !up_taken && !lk_taken)
    |=> (!(lk_valid && lk_addr == $past(lk_addr)) || !lk_taken));
endmodule

bind bpred_tagged bpred_tagged_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_taken(lk_taken),
  .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
  .valid(valid), .rr_ptr(rr_ptr)
);

// File: tb/bpred_tagged_tb_top.sv
module bpred_tagged_tb_top;
  localparam int N = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, up_valid = 1'b0, up_taken = 1'b0;
  logic [AW-1:0] lk_addr = '0, up_addr = '0;
  logic lk_taken;

  always #10 clk = ~clk;

  bpred_tagged #(.ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken)
  );

  int total = 0, bad = 0;
  bit    exp_q[$];
  string tag_q[$];

  bit          mv [N];
  logic [AW-1:0] mt [N];
  int          mc [N];
  int          mrr;

  function automatic int mfind(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && mt[i] == a) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    mrr = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; lk_valid = 1'b0; up_valid = 1'b0;
    model_reset();
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic step(input bit lkv, input logic [AW-1:0] lka,
                      input bit upv, input logic [AW-1:0] upa, input bit upt,
                      input string tag);
    int li, ui, fr, slot;
    bit alloc_up, alloc_lk;
    @(posedge clk); #2;
    li = mfind(lka);
    ui = mfind(upa);
    if (lkv) begin
      exp_q.push_back((li >= 0) ? (mc[li] >= 2) : 1'b1);
      tag_q.push_back(tag);
    end
    fr = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) fr = i;
    slot = (fr >= 0) ? fr : mrr;
    alloc_up = upv && ui < 0;
    alloc_lk = lkv && li < 0 && !alloc_up;
    if (upv && ui >= 0)
      mc[ui] = upt ? ((mc[ui] == 3) ? 3 : mc[ui] + 1) : ((mc[ui] == 0) ? 0 : mc[ui] - 1);
    if (alloc_up || alloc_lk) begin
      mv[slot] = 1'b1;
      mt[slot] = alloc_up ? upa : lka;
      mc[slot] = alloc_up ? (upt ? 3 : 1) : 2;
      if (fr < 0) mrr = (mrr + 1) % N;
    end
    lk_valid = lkv; lk_addr = lka;
    up_valid = upv; up_addr = upa; up_taken = upt;
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag);
    step(1'b1, a, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic upd(input logic [AW-1:0] a, input bit t, input string tag);
    step(1'b0, '0, 1'b1, a, t, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty: actual=%0b expected=none", lk_taken);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (lk_taken !== e) begin
          bad++;
          $display("FAIL %s addr=%h actual=%0b expected=%0b", t, lk_addr, lk_taken, e);
        end
      end
    end
  end

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 R2: empty table predicts taken; lookup allocates at 2
    look(32'h1000, "R1");
    upd(32'h1000, 1'b0, "R2");
    look(32'h1000, "R2");
    // R3 R4: walk up to saturation
    upd(32'h1000, 1'b1, "R4");
    look(32'h1000, "R3");
    upd(32'h1000, 1'b1, "R4");
    upd(32'h1000, 1'b1, "R4");
    upd(32'h1000, 1'b1, "R4");
    // R6: two mispredictions from strong taken
    upd(32'h1000, 1'b0, "R6");
    look(32'h1000, "R6");
    upd(32'h1000, 1'b0, "R6");
    look(32'h1000, "R6");
    // R5: saturate at 0, then R6 from strong not-taken
    upd(32'h1000, 1'b0, "R5");
    upd(32'h1000, 1'b0, "R5");
    upd(32'h1000, 1'b0, "R5");
    upd(32'h1000, 1'b1, "R6");
    look(32'h1000, "R5");
    upd(32'h1000, 1'b1, "R6");
    look(32'h1000, "R6");
    // R7: update to unseen address allocates then applies
    upd(32'h2000, 1'b0, "R7");
    look(32'h2000, "R7");
    upd(32'h2004, 1'b1, "R7");
    upd(32'h2004, 1'b0, "R7");
    look(32'h2004, "R7");
    // R8: same-cycle lookup and update see the old counter
    step(1'b1, 32'h2000, 1'b1, 32'h2000, 1'b1, "R8");
    look(32'h2000, "R8");
    step(1'b1, 32'h3000, 1'b1, 32'h3000, 1'b0, "R10");
    look(32'h3000, "R10");
    // R10: both miss, different addresses
    step(1'b1, 32'h3100, 1'b1, 32'h3200, 1'b0, "R10");
    look(32'h3200, "R10");
    // R1: reset forgets trained entries
    do_reset();
    look(32'h2000, "R1");
    // R9: fill, then evict in rotating order
    do_reset();
    for (int i = 0; i < N; i++) look(32'h100 + i, "R9");
    upd(32'h100, 1'b0, "R9");
    upd(32'h100, 1'b0, "R9");
    upd(32'h101, 1'b0, "R9");
    upd(32'h101, 1'b0, "R9");
    upd(32'h102, 1'b0, "R9");
    upd(32'h102, 1'b0, "R9");
    look(32'h100, "R9");
    look(32'h900, "R9");
    look(32'h101, "R9");
    look(32'h100, "R9");
    look(32'h102, "R9");
    // mixed stress across both ports
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom % 2), 32'h40 + 4 * ($urandom % 24),
           1'($urandom % 2), 32'h40 + 4 * ($urandom % 24), 1'($urandom % 2),
           "R9 R10 mixed");
    end
    step(1'b0, '0, 1'b0, '0, 1'b0, "idle");
    @(posedge clk); @(negedge clk);
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule